// File: doc/BRIEF.md
# Five-Level Multicarrier Gate Pulse Distributor

This block turns a signed digital modulation reference into the four gate commands of a single-phase five-level rectifier bridge. One up/down counter makes a symmetric triangle, and four copies of it are stacked into four adjacent bands of equal height. The bands together cover the full signed range of the reference. The reference is compared with every band carrier. The four comparison bits and the polarity of the reference then decode to a gate pattern in which at most one switch conducts.

Before the comparison, the reference is multiplied by a signed capacitor-balancing factor. An outer loop supplies this factor. The block forces its magnitude into the range 0.5 to 1. The product saturates at the reference limits; it never wraps. Reference, factor and carrier half-period are latched once per carrier cycle, at the valley, and a one-cycle sync pulse marks each valley. The carrier period is 2·`half_period` clock cycles, so a 250 MHz clock with `half_period` = 2500 gives a 50 kHz switching frequency.

Top module: `mlpwm_distributor`

## Requirements
- R1: While `rst` is high, and on the first falling edge after it, `gate` is 4'b0000 and `sync` is 0.
- R2: A clock edge that sees `en` low drives `gate` to 0 and `sync` to 0 and freezes the carrier counter. Counting resumes from where it stopped.
- R3: The counter goes 0,1,…,P,P−1,…,1,0 with P = max(`half_period`, 2). `sync` is high for exactly one cycle, one edge after each valley (count 0) that sees `en` high, so pulses are 2·P cycles apart.
- R4: `ref_in`, `bal_in` and `half_period` are latched only at a valley edge with `en` high. A change at any other time has no effect on `gate` until the next valley.
- R5: The balancing factor is a Q2.14 signed value (16384 = 1.0). Values above 16384 act as 16384 and values below −16384 act as −16384. Values from 0 up to 8191 act as 8192, and values from −8191 up to −1 act as −8192.
- R6: The scaled reference is s = (factor·`ref_in`) >>> 14, an arithmetic shift. It is saturated to [−32768, 32767].
- R7: The level is L = (s·P) >>> 14, and the band carriers are k0 = P+c, k1 = c, k2 = c−P and k3 = c−2P, where c is the count. Each hit bit hk is 1 when L > kk. The gates decode as: `gate[0]` = !h2 & h3, `gate[1]` = !h0 & h1, `gate[2]` = h0 & h1 & (s>0), `gate[3]` = !h2 & !h3 & (s<0). The value registered at an edge uses the count and latched sample held before that edge.
- R8: At most one bit of `gate` is high in any cycle.
- R9: When s = 0, `gate[2]` and `gate[3]` stay low.
- R10: A new `half_period` takes effect only at a valley. The shape of the ramp in progress is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces gates off and freezes the carrier |
| ref_in | input | 16 | Signed modulation reference sample |
| bal_in | input | 16 | Signed Q2.14 balancing factor |
| half_period | input | 12 | Carrier half-period in clock cycles (minimum 2) |
| gate | output | 4 | Registered gate commands, bit 0..3 |
| sync | output | 1 | One-cycle pulse after each carrier valley |

## Verification
`sync` rises on the edge after the valley edge. A new sample first shows on `gate` at the edge that follows the valley edge, because the gate register reads the latched sample one edge after that sample is captured. A value on `ref_in` therefore reaches `gate` two edges after the valley cycle in which it is presented. The bench keeps a behavioural model that advances on every rising edge from the same inputs. It compares `gate` and `sync` with that model at every falling edge, so each result is sampled half a cycle after the edge that registers it. Stimulus is driven at the falling edges. Inputs that change between valleys are expected to have no effect, and the model checks that they do not.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

    localparam int REF_W    = 16;
    localparam int BAL_W    = 16;
    localparam int BAL_FRAC = 14;
    localparam int PER_W    = 12;
    localparam int NBAND    = 4;
    localparam int PER_MIN  = 2;
    localparam int PROD_W   = REF_W + BAL_W;
    localparam int LVL_W    = REF_W + PER_W + 1;

    localparam logic signed [BAL_W-1:0]  BAL_ONE  = BAL_W'(2 ** BAL_FRAC);
    localparam logic signed [BAL_W-1:0]  BAL_HALF = BAL_W'(2 ** (BAL_FRAC - 1));
    localparam logic signed [PROD_W-1:0] SAT_HI   = PROD_W'(2 ** (REF_W - 1) - 1);
    localparam logic signed [PROD_W-1:0] SAT_LO   = -SAT_HI - PROD_W'(1);

    typedef enum logic {RAMP_UP, RAMP_DOWN} ramp_dir_e;

    typedef struct packed {
        logic                    pos;
        logic                    neg;
        logic signed [LVL_W-1:0] lvl;
    } ref_sample_t;

    function automatic logic [PER_W-1:0] clamp_period(input logic [PER_W-1:0] p);
        return (p < PER_W'(PER_MIN)) ? PER_W'(PER_MIN) : p;
    endfunction

    function automatic logic signed [BAL_W-1:0] clamp_bal(input logic signed [BAL_W-1:0] b);
        if (b > BAL_ONE)                  return BAL_ONE;
        else if (b < -BAL_ONE)            return -BAL_ONE;
        else if (b >= 0 && b < BAL_HALF)  return BAL_HALF;
        else if (b < 0 && b > -BAL_HALF)  return -BAL_HALF;
        else                              return b;
    endfunction

    function automatic logic signed [REF_W-1:0] scale_sat(input logic signed [BAL_W-1:0] b,
                                                          input logic signed [REF_W-1:0] r);
        logic signed [PROD_W-1:0] prod;
        logic signed [PROD_W-1:0] sh;
        prod = PROD_W'(b) * PROD_W'(r);
        sh   = prod >>> BAL_FRAC;
        if (sh > SAT_HI)      return SAT_HI[REF_W-1:0];
        else if (sh < SAT_LO) return SAT_LO[REF_W-1:0];
        else                  return sh[REF_W-1:0];
    endfunction

    function automatic ref_sample_t make_sample(input logic signed [REF_W-1:0] s,
                                                input logic [PER_W-1:0] p);
        ref_sample_t o;
        logic signed [LVL_W-1:0] m;
        m     = LVL_W'(s) * $signed({{(LVL_W-PER_W){1'b0}}, p});
        o.lvl = m >>> (REF_W - 2);
        o.pos = (s > 0);
        o.neg = (s < 0);
        return o;
    endfunction

    function automatic logic [NBAND-1:0] decode_gates(input logic [NBAND-1:0] h,
                                                      input logic pos, input logic neg);
        logic [NBAND-1:0] g;
        g[0] = ~h[2] &  h[3];
        g[1] = ~h[0] &  h[1];
        g[2] =  h[0] &  h[1] & pos;
        g[3] = ~h[2] & ~h[3] & neg;
        return g;
    endfunction

endpackage

// File: rtl/mlpwm_ramp.sv
module mlpwm_ramp
    import mlpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PER_W-1:0] p_hold,
    output logic [PER_W-1:0] cnt,
    output logic             valley
);
    ramp_dir_e dir;

    assign valley = en && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            dir <= RAMP_UP;
        end else if (en) begin
            if (dir == RAMP_UP) begin
                if (cnt >= p_hold - PER_W'(1)) begin
                    cnt <= p_hold;
                    dir <= RAMP_DOWN;
                end else begin
                    cnt <= cnt + PER_W'(1);
                end
            end else begin
                if (cnt <= PER_W'(1)) begin
                    cnt <= '0;
                    dir <= RAMP_UP;
                end else begin
                    cnt <= cnt - PER_W'(1);
                end
            end
        end
    end

    // R3
    cnt_in_band_chk: assert property (@(posedge clk) disable iff (rst) cnt <= p_hold);

endmodule

// File: rtl/mlpwm_sampler.sv
module mlpwm_sampler
    import mlpwm_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    valley,
    input  logic signed [REF_W-1:0] ref_in,
    input  logic signed [BAL_W-1:0] bal_in,
    input  logic [PER_W-1:0]        half_period,
    output ref_sample_t             smp,
    output logic [PER_W-1:0]        p_hold
);
    logic [PER_W-1:0]        p_new;
    logic signed [REF_W-1:0] scaled;

    always_comb begin
        p_new  = clamp_period(half_period);
        scaled = scale_sat(clamp_bal(bal_in), ref_in);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smp    <= '0;
            p_hold <= PER_W'(PER_MIN);
        end else if (valley) begin
            smp    <= make_sample(scaled, p_new);
            p_hold <= p_new;
        end
    end

    // R4
    hold_between_valleys_chk: assert property (@(posedge clk) disable iff (rst)
        !valley |=> $stable(smp));

    // R10
    period_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valley |=> $stable(p_hold));

endmodule

// File: rtl/mlpwm_gates.sv
module mlpwm_gates
    import mlpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              valley,
    input  logic [PER_W-1:0]  cnt,
    input  logic [PER_W-1:0]  p_hold,
    input  ref_sample_t       smp,
    output logic [NBAND-1:0]  gate_q,
    output logic              sync_q
);
    logic signed [LVL_W-1:0] cnt_s;
    logic signed [LVL_W-1:0] p_s;
    logic signed [LVL_W-1:0] car [NBAND];
    logic [NBAND-1:0]        hit;

    assign cnt_s = $signed({{(LVL_W-PER_W){1'b0}}, cnt});
    assign p_s   = $signed({{(LVL_W-PER_W){1'b0}}, p_hold});

    for (genvar k = 0; k < NBAND; k++) begin : g_band
        localparam int OFS = 1 - k;
        assign car[k] = cnt_s + $signed(LVL_W'(OFS)) * p_s;
        assign hit[k] = smp.lvl > car[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= '0;
            sync_q <= 1'b0;
        end else begin
            gate_q <= en ? decode_gates(hit, smp.pos, smp.neg) : '0;
            sync_q <= valley;
        end
    end

    // R8
    single_gate_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(gate_q));

    // R2
    idle_off_chk: assert property (@(posedge clk) disable iff (rst) !en |=> gate_q == '0);

    // R3
    sync_single_chk: assert property (@(posedge clk) disable iff (rst) sync_q |=> !sync_q);

    // R9
    upper_pol_chk: assert property (@(posedge clk) disable iff (rst) gate_q[2] |-> $past(smp.pos));

    // R9
    lower_pol_chk: assert property (@(posedge clk) disable iff (rst) gate_q[3] |-> $past(smp.neg));

endmodule

// File: rtl/mlpwm_distributor.sv
module mlpwm_distributor
    import mlpwm_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic signed [REF_W-1:0] ref_in,
    input  logic signed [BAL_W-1:0] bal_in,
    input  logic [PER_W-1:0]        half_period,
    output logic [NBAND-1:0]        gate,
    output logic                    sync
);
    logic [PER_W-1:0] cnt;
    logic [PER_W-1:0] p_hold;
    logic             valley;
    ref_sample_t      smp;

    mlpwm_ramp u_ramp (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .p_hold (p_hold),
        .cnt    (cnt),
        .valley (valley)
    );

    mlpwm_sampler u_smp (
        .clk         (clk),
        .rst         (rst),
        .valley      (valley),
        .ref_in      (ref_in),
        .bal_in      (bal_in),
        .half_period (half_period),
        .smp         (smp),
        .p_hold      (p_hold)
    );

    mlpwm_gates u_gates (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .valley (valley),
        .cnt    (cnt),
        .p_hold (p_hold),
        .smp    (smp),
        .gate_q (gate),
        .sync_q (sync)
    );

endmodule

// File: tb/mlpwm_distributor_test.sv
module mlpwm_distributor_test;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               en  = 1'b0;
    logic signed [15:0] ref_in = '0;
    logic signed [15:0] bal_in = 16'sd16384;
    logic [11:0]        half_period = 12'd8;
    logic [3:0]         gate;
    logic               sync;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    bit    done  = 1'b0;
    string tag   = "R1";

    integer m_cnt = 0, m_p = 2, m_r = 0;
    bit     m_up = 1'b1, m_pos = 1'b0, m_neg = 1'b0;
    logic [3:0] e_gate = '0;
    logic       e_sync = 1'b0;
    integer     lcg = 12345;

    mlpwm_distributor uut (
        .clk(clk), .rst(rst), .en(en), .ref_in(ref_in), .bal_in(bal_in),
        .half_period(half_period), .gate(gate), .sync(sync)
    );

    always #2 clk = ~clk;

    function automatic logic [3:0] mdl_gates(integer c, integer p, integer r, bit pos, bit neg);
        bit above_top, above_b1, above_b2, above_bot;
        logic [3:0] g;
        above_top = r > (c + p);
        above_b1  = r > c;
        above_b2  = r > (c - p);
        above_bot = r > (c - 2 * p);
        g[0] = !above_b2 && above_bot;
        g[1] = !above_top && above_b1;
        g[2] = above_top && above_b1 && pos;
        g[3] = !above_b2 && !above_bot && neg;
        return g;
    endfunction

    always @(posedge clk) begin
        integer pl, bc, pr, s;
        if (rst) begin
            m_cnt = 0; m_up = 1'b1; m_p = 2; m_r = 0; m_pos = 1'b0; m_neg = 1'b0;
            e_gate = '0; e_sync = 1'b0;
        end else if (!en) begin
            e_gate = '0; e_sync = 1'b0;
        end else begin
            e_gate = mdl_gates(m_cnt, m_p, m_r, m_pos, m_neg);
            e_sync = (m_cnt == 0);
            if (m_cnt == 0) begin
                pl = (half_period < 2) ? 2 : half_period;
                bc = bal_in;
                if (bc > 16384) bc = 16384;
                else if (bc < -16384) bc = -16384;
                else if (bc >= 0 && bc < 8192) bc = 8192;
                else if (bc < 0 && bc > -8192) bc = -8192;
                pr = bc * ref_in;
                s  = pr >>> 14;
                if (s > 32767) s = 32767;
                if (s < -32768) s = -32768;
                m_r = (s * pl) >>> 14;
                m_pos = s > 0; m_neg = s < 0; m_p = pl;
            end
            if (m_up) begin
                if (m_cnt >= m_p - 1) begin m_cnt = m_p; m_up = 1'b0; end
                else m_cnt = m_cnt + 1;
            end else begin
                if (m_cnt <= 1) begin m_cnt = 0; m_up = 1'b1; end
                else m_cnt = m_cnt - 1;
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cyc > 0 && !done) begin
            n_chk++;
            if (gate !== e_gate) begin
                n_bad++;
                $display("FAIL %s gate got %b exp %b (cycle %0d)", tag, gate, e_gate, cyc);
            end
            n_chk++;
            if (sync !== e_sync) begin
                n_bad++;
                $display("FAIL %s/R3 sync got %b exp %b (cycle %0d)", tag, sync, e_sync, cyc);
            end
            n_chk++;
            if ($countones(gate) > 1) begin
                n_bad++;
                $display("FAIL R8 gate got %b exp at most one bit", gate);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL R3 watchdog cycles got %0d exp < 150000", cyc);
            summary();
        end
    end

    task automatic run(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_scramble(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lcg = lcg * 1103515245 + 12345;
            ref_in = lcg[30:15];
        end
    endtask

    initial begin
        int gap;
        // R1: reset state
        tag = "R1";
        run(4);
        rst = 1'b0;
        run(1);
        n_chk++;
        if (gate !== 4'b0000 || sync !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 gate/sync got %b/%b exp 0000/0", gate, sync);
        end
        // R7: positive and negative references
        en = 1'b1;
        tag = "R7"; half_period = 12'd8; bal_in = 16'sd16384; ref_in = 16'sd20000; run(60);
        ref_in = -16'sd20000; run(60);
        ref_in = 16'sd9000; run(40);
        ref_in = -16'sd30000; half_period = 12'd16; run(100);
        // R4: reference changes every cycle
        tag = "R4"; run_scramble(300);
        // R5: factor clamping
        tag = "R5"; ref_in = 16'sd24000;
        bal_in = 16'sd3000;    run(70);
        bal_in = 16'sd30000;   run(70);
        bal_in = -16'sd100;    run(70);
        bal_in = -16'sd32768;  run(70);
        bal_in = 16'sd0;       run(70);
        bal_in = 16'sd12000;   run(70);
        // R6: saturation at both ends
        tag = "R6"; bal_in = -16'sd16384; ref_in = -16'sd32768; run(70);
        bal_in = 16'sd16384; run(70);
        bal_in = -16'sd20000; ref_in = 16'sd32767; run(70);
        // R9: zero reference
        tag = "R9"; ref_in = 16'sd0; bal_in = 16'sd16384; run(70);
        // R10: period change mid-ramp, and clamp below minimum
        tag = "R10"; ref_in = 16'sd15000; run(5); half_period = 12'd5; run(40);
        half_period = 12'd1; run(30);
        half_period = 12'd0; run(20);
        // R3: measured sync spacing for P = 6
        tag = "R3"; half_period = 12'd6; run(30);
        gap = 0;
        while (sync !== 1'b1) run(1);
        run(1);
        while (sync !== 1'b1) begin run(1); gap++; end
        n_chk++;
        if (gap + 1 != 12) begin
            n_bad++;
            $display("FAIL R3 sync spacing got %0d exp 12", gap + 1);
        end
        // R2: enable low mid-ramp
        tag = "R2"; ref_in = -16'sd12000; run(7); en = 1'b0; run(9);
        n_chk++;
        if (gate !== 4'b0000) begin
            n_bad++;
            $display("FAIL R2 gate got %b exp 0000", gate);
        end
        en = 1'b1; run(50);
        // R7: full-rate carrier, 50 kHz at 250 MHz
        tag = "R7"; half_period = 12'd2500; ref_in = 16'sd21000; run(12000);
        done = 1'b1;
        summary();
    end

endmodule